// File: doc/BRIEF.md
# Audio Codec Mixer Register File

This block is the 16-bit register file of an audio codec mixer. It sits behind a 256-byte I/O window. A host reaches it through a simple register bus: address, access size in bytes, write strobe with write data, and read strobe with registered read data. The file holds the volume, gain, record-select, power-down, extended-audio and sample-rate registers. Each register class has its own write rule.

The decoded mute flag and the left and right attenuation fields of each output-volume channel are exported continuously, for use by the analog mixing logic. Every access of any size sends a one-cycle pulse that clears a shared codec-access semaphore held elsewhere. A separate one-cycle pulse for each stream reports an accepted sample-rate change, so the stream can be reopened at the new rate.

Top module: `codec_mixer_regs`

## Requirements
- R1: Only accesses with `accSize` equal to 2 reach the registers. A read of any other size returns 0xFFFFFFFF. A write of any other size changes no register.
- R2: `semClr` is high for exactly the one cycle after each cycle in which `rdEn` or `wrEn` is high, whatever the access size. It is low after an idle cycle.
- R3: After reset, every register holds its default value, read data appears one cycle after `rdEn`, and a word read returns the register in bits [15:0] with zeros above. The defaults are:
  - 0x8000 at offsets 0x02, 0x04, 0x10 and 0x18.
  - 0x000F at offset 0x26.
  - 0x0001 at offset 0x28.
  - 0xBB80 at offsets 0x2C, 0x32 and 0x34.
  - 0x4D58 at offset 0x7C and 0x0031 at offset 0x7E.
  - 0 everywhere else.
- R4: Volume channel k (k = 0..3 at offsets 0x02, 0x04, 0x10 and 0x18) drives `volMute[k]` from register bit 15. It drives left attenuation from bits [13:8] and right attenuation from bits [5:0], each on slice [6k+5:6k] of `volLeft` and `volRight`.
- R5: A word write to the power-down register at offset 0x26 keeps bits [3:0] at their current value and stores bits [15:4] from the write data.
- R6: Word writes to offsets 0x28, 0x7C and 0x7E leave those registers unchanged.
- R7: A word write to the extended control register at offset 0x2A stores the data.
  - If data bit 0 (variable-rate audio) is 0, the registers at 0x2C and 0x32 are set to 0xBB80 in the same cycle.
  - If data bit 3 (variable-rate mic) is 0, the register at 0x34 is set to 0xBB80 in the same cycle.
- R8: A word write to 0x2C or 0x32 is stored only while bit 0 of the extended control register is 1. A word write to 0x34 is stored only while its bit 3 is 1. Each stored rate write pulses `rateChanged` for one cycle, the next cycle: bit 0 for 0x2C, bit 1 for 0x32, bit 2 for 0x34. A refused write changes nothing and gives no pulse.
- R9: A word write to any offset without a rule above stores the data as written. Address bit 0 is ignored for word accesses.
- R10: A word write of any value to offset 0x00 returns every register to its R3 default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accAddr | input | 8 | Byte offset in the window |
| accSize | input | 3 | Access size in bytes (1, 2 or 4) |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data, bits [15:0] used for word writes |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Read data, valid the cycle after `rdEn` |
| semClr | output | 1 | Codec-access semaphore clear pulse |
| rateChanged | output | 3 | Per-stream accepted rate-change pulse |
| volMute | output | 4 | Mute flag per volume channel |
| volLeft | output | 24 | Left attenuation, 6 bits per channel |
| volRight | output | 24 | Right attenuation, 6 bits per channel |

## Verification
Every result is due one clock edge after the access that causes it:
- Read data, `semClr` and `rateChanged` are registers loaded at the edge that takes the strobe.
- Register contents, and the volume fields decoded from them, also change at that edge.

The bench drives each access at a falling edge, drops the strobe at the next falling edge, and samples all outputs at that same moment, half a cycle after the edge that updated them. Two full sweeps write all 128 word locations and read them back. One sweep leaves the variable-rate bits clear and the other sets them, so both the refused and the accepted rate-write paths are compared against a bench-side model.

// File: rtl/mixreg_pkg.sv
package mixreg_pkg;

  localparam int WIN_BYTES = 256;
  localparam int DATA_W    = 16;
  localparam int BUS_W     = 32;
  localparam int WORDS     = WIN_BYTES / (DATA_W / 8);
  localparam int IDX_W     = $clog2(WORDS);
  localparam int ADDR_W    = $clog2(WIN_BYTES);
  localparam int ATT_W     = 6;
  localparam int NUM_VOL   = 4;
  localparam int NUM_RATE  = 3;

  localparam int EXT_VRA_BIT = 0;
  localparam int EXT_VRM_BIT = 3;

  // word indices (byte offset / 2)
  localparam logic [IDX_W-1:0] IX_RESET     = IDX_W'(8'h00 >> 1);
  localparam logic [IDX_W-1:0] IX_MASTER    = IDX_W'(8'h02 >> 1);
  localparam logic [IDX_W-1:0] IX_HPHONE    = IDX_W'(8'h04 >> 1);
  localparam logic [IDX_W-1:0] IX_LINEVOL   = IDX_W'(8'h10 >> 1);
  localparam logic [IDX_W-1:0] IX_PCMVOL    = IDX_W'(8'h18 >> 1);
  localparam logic [IDX_W-1:0] IX_PWR       = IDX_W'(8'h26 >> 1);
  localparam logic [IDX_W-1:0] IX_EXTID     = IDX_W'(8'h28 >> 1);
  localparam logic [IDX_W-1:0] IX_EXTCTL    = IDX_W'(8'h2A >> 1);
  localparam logic [IDX_W-1:0] IX_RATE_DAC  = IDX_W'(8'h2C >> 1);
  localparam logic [IDX_W-1:0] IX_RATE_LINE = IDX_W'(8'h32 >> 1);
  localparam logic [IDX_W-1:0] IX_RATE_MIC  = IDX_W'(8'h34 >> 1);
  localparam logic [IDX_W-1:0] IX_VID1      = IDX_W'(8'h7C >> 1);
  localparam logic [IDX_W-1:0] IX_VID2      = IDX_W'(8'h7E >> 1);

  localparam logic [DATA_W-1:0] RATE_DEFAULT  = 16'hBB80;
  localparam logic [DATA_W-1:0] MUTE_DEFAULT  = 16'h8000;
  localparam logic [DATA_W-1:0] PWR_DEFAULT   = 16'h000F;
  localparam logic [DATA_W-1:0] EXTID_DEFAULT = 16'h0001;
  localparam logic [DATA_W-1:0] VID1_DEFAULT  = 16'h4D58;
  localparam logic [DATA_W-1:0] VID2_DEFAULT  = 16'h0031;

  // command from control to datapath
  typedef struct packed {
    logic              store;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] value;
    logic              restore;
    logic              forceAudio;
    logic              forceMic;
    logic              rdWord;
    logic              rdOther;
    logic [IDX_W-1:0]  rdIdx;
  } mixCmd_t;

  function automatic logic [DATA_W-1:0] defaultOf(logic [IDX_W-1:0] ix);
    logic [DATA_W-1:0] v;
    case (ix)
      IX_MASTER, IX_HPHONE, IX_LINEVOL, IX_PCMVOL: v = MUTE_DEFAULT;
      IX_PWR:                                      v = PWR_DEFAULT;
      IX_EXTID:                                    v = EXTID_DEFAULT;
      IX_RATE_DAC, IX_RATE_LINE, IX_RATE_MIC:      v = RATE_DEFAULT;
      IX_VID1:                                     v = VID1_DEFAULT;
      IX_VID2:                                     v = VID2_DEFAULT;
      default:                                     v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [IDX_W-1:0] volIndex(int k);
    logic [IDX_W-1:0] v;
    case (k)
      0:       v = IX_MASTER;
      1:       v = IX_HPHONE;
      2:       v = IX_LINEVOL;
      default: v = IX_PCMVOL;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/mixreg_ctrl.sv
module mixreg_ctrl
  import mixreg_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   accAddr,
  input  logic [2:0]          accSize,
  input  logic                wrEn,
  input  logic [BUS_W-1:0]    wrData,
  input  logic                rdEn,
  input  logic [DATA_W-1:0]   extCtl,
  input  logic [3:0]          pwrLow,
  output mixCmd_t             cmd,
  output logic                semClr,
  output logic [NUM_RATE-1:0] rateChanged
);

  logic                isWord;
  logic [IDX_W-1:0]    wIdx;
  logic [NUM_RATE-1:0] rateHit;
  logic                unusedHiBits;

  assign isWord       = (accSize == 3'd2);
  assign wIdx         = accAddr[ADDR_W-1:1];
  assign unusedHiBits = ^{wrData[BUS_W-1:DATA_W], accAddr[0]};

  always_comb begin
    cmd            = '0;
    cmd.idx        = wIdx;
    cmd.value      = wrData[DATA_W-1:0];
    cmd.rdIdx      = wIdx;
    cmd.rdWord     = rdEn && isWord;
    cmd.rdOther    = rdEn && !isWord;
    rateHit        = '0;
    if (wrEn && isWord) begin
      case (wIdx)
        IX_RESET: cmd.restore = 1'b1;
        IX_VID1, IX_VID2, IX_EXTID: cmd.store = 1'b0;
        IX_PWR: begin
          cmd.store = 1'b1;
          cmd.value = {wrData[DATA_W-1:4], pwrLow};
        end
        IX_EXTCTL: begin
          cmd.store      = 1'b1;
          cmd.forceAudio = !wrData[EXT_VRA_BIT];
          cmd.forceMic   = !wrData[EXT_VRM_BIT];
        end
        IX_RATE_DAC: begin
          cmd.store  = extCtl[EXT_VRA_BIT];
          rateHit[0] = extCtl[EXT_VRA_BIT];
        end
        IX_RATE_LINE: begin
          cmd.store  = extCtl[EXT_VRA_BIT];
          rateHit[1] = extCtl[EXT_VRA_BIT];
        end
        IX_RATE_MIC: begin
          cmd.store  = extCtl[EXT_VRM_BIT];
          rateHit[2] = extCtl[EXT_VRM_BIT];
        end
        default: cmd.store = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      semClr      <= 1'b0;
      rateChanged <= '0;
    end else begin
      semClr      <= rdEn || wrEn;
      rateChanged <= rateHit;
    end
  end

  AST_SEM_ON_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (rdEn || wrEn) |=> semClr); // R2
  AST_SEM_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(rdEn || wrEn) |=> !semClr); // R2
  AST_RATE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rateChanged)); // R8
  AST_RATE_NEEDS_VRA: assert property (@(posedge clk) disable iff (rst)
    (wrEn && isWord && wIdx == IX_RATE_DAC && !extCtl[EXT_VRA_BIT]) |=> !rateChanged[0]); // R8
  AST_NARROW_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !isWord) |=> $past(!cmd.store && !cmd.restore)); // R1

endmodule

// File: rtl/mixreg_data.sv
module mixreg_data
  import mixreg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  mixCmd_t                   cmd,
  output logic [BUS_W-1:0]          rdData,
  output logic [DATA_W-1:0]         extCtl,
  output logic [3:0]                pwrLow,
  output logic [NUM_VOL-1:0]        volMute,
  output logic [NUM_VOL*ATT_W-1:0]  volLeft,
  output logic [NUM_VOL*ATT_W-1:0]  volRight
);

  logic [DATA_W-1:0] regFile [WORDS];
  logic [DATA_W-1:0] dacRate;
  logic [DATA_W-1:0] vid1Reg;

  always_ff @(posedge clk) begin
    if (rst || cmd.restore) begin
      for (int i = 0; i < WORDS; i++) regFile[i] <= defaultOf(IDX_W'(i));
    end else begin
      if (cmd.store) regFile[cmd.idx] <= cmd.value;
      if (cmd.forceAudio) begin
        regFile[IX_RATE_DAC]  <= RATE_DEFAULT;
        regFile[IX_RATE_LINE] <= RATE_DEFAULT;
      end
      if (cmd.forceMic) regFile[IX_RATE_MIC] <= RATE_DEFAULT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else if (cmd.rdWord) rdData <= {{(BUS_W-DATA_W){1'b0}}, regFile[cmd.rdIdx]};
    else if (cmd.rdOther) rdData <= '1;
  end

  assign extCtl  = regFile[IX_EXTCTL];
  assign pwrLow  = regFile[IX_PWR][3:0];
  assign dacRate = regFile[IX_RATE_DAC];
  assign vid1Reg = regFile[IX_VID1];

  generate
    for (genvar k = 0; k < NUM_VOL; k++) begin : g_vol
      localparam logic [IDX_W-1:0] VIX = volIndex(k);
      assign volMute[k]                 = regFile[VIX][DATA_W-1];
      assign volLeft[k*ATT_W +: ATT_W]  = regFile[VIX][8 +: ATT_W];
      assign volRight[k*ATT_W +: ATT_W] = regFile[VIX][0 +: ATT_W];
    end
  endgenerate

  AST_NARROW_READ_ONES: assert property (@(posedge clk) disable iff (rst)
    cmd.rdOther |=> (rdData == '1)); // R1
  AST_PWR_LOW_HELD: assert property (@(posedge clk) disable iff (rst)
    !cmd.restore |=> (pwrLow == $past(pwrLow))); // R5
  AST_VID_FIXED: assert property (@(posedge clk) disable iff (rst)
    vid1Reg == VID1_DEFAULT); // R6
  AST_DAC_RATE_GUARD: assert property (@(posedge clk) disable iff (rst)
    (dacRate != $past(dacRate)) |->
      $past(cmd.restore || cmd.forceAudio || (cmd.store && cmd.idx == IX_RATE_DAC))); // R8

endmodule

// File: rtl/codec_mixer_regs.sv
module codec_mixer_regs
  import mixreg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         accAddr,
  input  logic [2:0]                accSize,
  input  logic                      wrEn,
  input  logic [BUS_W-1:0]          wrData,
  input  logic                      rdEn,
  output logic [BUS_W-1:0]          rdData,
  output logic                      semClr,
  output logic [NUM_RATE-1:0]       rateChanged,
  output logic [NUM_VOL-1:0]        volMute,
  output logic [NUM_VOL*ATT_W-1:0]  volLeft,
  output logic [NUM_VOL*ATT_W-1:0]  volRight
);

  mixCmd_t           cmd;
  logic [DATA_W-1:0] extCtl;
  logic [3:0]        pwrLow;

  mixreg_ctrl u_ctrl (
    .clk(clk), .rst(rst), .accAddr(accAddr), .accSize(accSize),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .extCtl(extCtl),
    .pwrLow(pwrLow), .cmd(cmd), .semClr(semClr), .rateChanged(rateChanged)
  );

  mixreg_data u_data (
    .clk(clk), .rst(rst), .cmd(cmd), .rdData(rdData), .extCtl(extCtl),
    .pwrLow(pwrLow), .volMute(volMute), .volLeft(volLeft), .volRight(volRight)
  );

endmodule

// File: tb/codec_mixer_regs_tb.sv
module codec_mixer_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  accAddr = '0;
  logic [2:0]  accSize = 3'd2;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        semClr;
  logic [2:0]  rateChanged;
  logic [3:0]  volMute;
  logic [23:0] volLeft;
  logic [23:0] volRight;

  logic [15:0] mdl [NW];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_mixer_regs u_dut (
    .clk(clk), .rst(rst), .accAddr(accAddr), .accSize(accSize), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .semClr(semClr),
    .rateChanged(rateChanged), .volMute(volMute), .volLeft(volLeft), .volRight(volRight)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] dflt(int i);
    case (i)
      8'h02/2, 8'h04/2, 8'h10/2, 8'h18/2: return 16'h8000;
      8'h26/2: return 16'h000F;
      8'h28/2: return 16'h0001;
      8'h2C/2, 8'h32/2, 8'h34/2: return 16'hBB80;
      8'h7C/2: return 16'h4D58;
      8'h7E/2: return 16'h0031;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tagOf(int i);
    case (i)
      0: return "R10";
      8'h26/2: return "R5";
      8'h28/2, 8'h7C/2, 8'h7E/2: return "R6";
      8'h2A/2: return "R7";
      8'h2C/2, 8'h32/2, 8'h34/2: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NW; i++) mdl[i] = dflt(i);
  endtask

  task automatic doWrite(logic [7:0] a, logic [2:0] sz, logic [31:0] d);
    int ix;
    logic [2:0] expRate;
    ix = int'(a[7:1]);
    expRate = 3'b000;
    @(negedge clk);
    accAddr = a; accSize = sz; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check("R2", {31'b0, semClr}, 32'd1);
    if (sz == 3'd2) begin
      case (ix)
        0: modelReset();
        8'h28/2, 8'h7C/2, 8'h7E/2: ;
        8'h26/2: mdl[ix] = {d[15:4], mdl[ix][3:0]};
        8'h2A/2: begin
          mdl[ix] = d[15:0];
          if (!d[0]) begin mdl[8'h2C/2] = 16'hBB80; mdl[8'h32/2] = 16'hBB80; end
          if (!d[3]) mdl[8'h34/2] = 16'hBB80;
        end
        8'h2C/2: if (mdl[8'h2A/2][0]) begin mdl[ix] = d[15:0]; expRate = 3'b001; end
        8'h32/2: if (mdl[8'h2A/2][0]) begin mdl[ix] = d[15:0]; expRate = 3'b010; end
        8'h34/2: if (mdl[8'h2A/2][3]) begin mdl[ix] = d[15:0]; expRate = 3'b100; end
        default: mdl[ix] = d[15:0];
      endcase
      check("R8", {29'b0, rateChanged}, {29'b0, expRate});
    end else begin
      check("R1", {29'b0, rateChanged}, 32'd0);
    end
  endtask

  task automatic doRead(logic [7:0] a, logic [2:0] sz, output logic [31:0] v);
    @(negedge clk);
    accAddr = a; accSize = sz; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
    check("R2", {31'b0, semClr}, 32'd1);
  endtask

  task automatic checkWord(string req, int ix);
    logic [31:0] v;
    doRead(8'(ix * 2), 3'd2, v);
    check(req, v, {16'h0, mdl[ix]});
  endtask

  task automatic checkVol();
    int vix [4] = '{1, 2, 8, 12};
    for (int k = 0; k < 4; k++) begin
      check("R4", {31'b0, volMute[k]}, {31'b0, mdl[vix[k]][15]});
      check("R4", {26'b0, volLeft[k*6 +: 6]}, {26'b0, mdl[vix[k]][13:8]});
      check("R4", {26'b0, volRight[k*6 +: 6]}, {26'b0, mdl[vix[k]][5:0]});
    end
  endtask

  task automatic sweep(logic [15:0] pat);
    for (int i = 0; i < NW; i++) doWrite(8'(i * 2), 3'd2, {16'hDEAD, 16'(i * 16'h0307) ^ pat});
    for (int i = 0; i < NW; i++) checkWord(tagOf(i), i);
    checkVol();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    modelReset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state R3
    check("R3", {31'b0, semClr}, 32'd0);
    check("R3", {29'b0, rateChanged}, 32'd0);
    check("R3", rdData, 32'd0);
    check("R3", {28'b0, volMute}, 32'hF);
    for (int i = 0; i < NW; i++) checkWord("R3", i);
    checkVol();
    // idle cycle: no semaphore pulse R2
    @(negedge clk);
    check("R2", {31'b0, semClr}, 32'd0);

    // size filter R1
    doWrite(8'h02, 3'd1, 32'h0000_1234);
    doWrite(8'h02, 3'd4, 32'h0000_1234);
    checkWord("R1", 1);
    check("R1", {16'h0, mdl[1]}, 32'h0000_8000);
    doRead(8'h02, 3'd1, v); check("R1", v, 32'hFFFF_FFFF);
    doRead(8'h02, 3'd4, v); check("R1", v, 32'hFFFF_FFFF);
    doRead(8'h00, 3'd0, v); check("R1", v, 32'hFFFF_FFFF);

    // odd address lands on word R9, volume decode R4
    doWrite(8'h03, 3'd2, 32'h0000_2A15);
    checkWord("R9", 1);
    check("R4", {31'b0, volMute[0]}, 32'd0);
    check("R4", {26'b0, volLeft[5:0]}, 32'h2A);
    check("R4", {26'b0, volRight[5:0]}, 32'h15);
    doRead(8'h03, 3'd2, v); check("R9", v, 32'h0000_2A15);

    // rate gating R8 and forcing R7
    doWrite(8'h2C, 3'd2, 32'h0000_5622);
    checkWord("R8", 8'h2C/2);
    check("R8", {16'h0, mdl[8'h2C/2]}, 32'h0000_BB80);
    doWrite(8'h2A, 3'd2, 32'h0000_0009);
    doWrite(8'h2C, 3'd2, 32'h0000_5622);
    doWrite(8'h32, 3'd2, 32'h0000_AC44);
    doWrite(8'h34, 3'd2, 32'h0000_1F40);
    checkWord("R8", 8'h2C/2); checkWord("R8", 8'h32/2); checkWord("R8", 8'h34/2);
    doWrite(8'h2A, 3'd2, 32'h0000_0008);
    checkWord("R7", 8'h2C/2); checkWord("R7", 8'h32/2); checkWord("R7", 8'h34/2);
    check("R7", {16'h0, mdl[8'h34/2]}, 32'h0000_1F40);
    doWrite(8'h2A, 3'd2, 32'h0000_0000);
    checkWord("R7", 8'h34/2);
    check("R7", {16'h0, mdl[8'h34/2]}, 32'h0000_BB80);

    // power-down low nibble R5
    doWrite(8'h26, 3'd2, 32'h0000_FFF0);
    checkWord("R5", 8'h26/2);
    check("R5", {16'h0, mdl[8'h26/2]}, 32'h0000_FFFF);
    doWrite(8'h26, 3'd2, 32'h0000_0000);
    checkWord("R5", 8'h26/2);

    // identification writes ignored R6
    doWrite(8'h7C, 3'd2, 32'h0000_0000);
    doWrite(8'h7E, 3'd2, 32'h0000_FFFF);
    doWrite(8'h28, 3'd2, 32'h0000_0000);
    checkWord("R6", 8'h7C/2); checkWord("R6", 8'h7E/2); checkWord("R6", 8'h28/2);

    // exhaustive sweeps with rate enables clear, then set
    sweep(16'hA5A5);
    sweep(16'h5A5A);

    // reset register R10
    doWrite(8'h00, 3'd2, 32'h0000_1357);
    for (int i = 0; i < NW; i++) checkWord("R10", i);
    check("R10", {28'b0, volMute}, 32'hF);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule